// File: doc/BRIEF.md
# NAND Command Cycle Sequencer

This block turns one high-level flash request into the cycles that a NAND bus carries. A request gives an operation byte, an optional column, an optional page (row) address and a chip-select level. The block emits a command-latch cycle, then the address-latch cycles, an optional second command byte and a data phase whose length it works out itself. It then waits for the flash ready line and reports completion or timeout with a one-cycle done pulse. One bus event is presented per clock on `bus_valid`/`bus_kind`/`bus_byte`. Pin setup and hold timing, data movement and error correction are handled elsewhere.

The geometry is fixed by parameters: page size, spare size, and whether the device is big enough to need a third row byte. Two-step operations are folded into one. A program-load or erase-setup request is only stored. The matching confirm request later sends the stored command, its addresses and data, and then the confirm byte. While a setup is stored, only a confirm is accepted.

The 32-bit control word describing the launched operation is held on `ctl_word` until the next launch.

Top module: `nand_cmd_seq`

## Requirements
- R1: The number of address cycles is 2 for a column alone. A page address adds 2 cycles, plus 1 more when `LONG_ROW` is set. A page alone therefore gives 2, or 3 with `LONG_ROW`. No address gives 0.
- R2: Address bytes go out least significant first: the low and high byte of the first word, then bytes 0, 1 and 2 of the second word. With a column, the first word is the column and the second is the page. With a page alone, the first word is page bits 15:0 and the second is the page shifted right by 16.
- R3: Read-ID (0x90) and read-status (0x70) always use exactly one address cycle and a 4-byte read data phase.
- R4: On a large page device (`PAGE_BYTES` > 512), a spare read (0x50) is sent as a page read (0x00), with the column increased by `PAGE_BYTES`.
- R5: Page reads (0x00, 0x01, 0x50, 0x05) and program loads (0x80) move `PAGE_BYTES + SPARE_BYTES - column` bytes (0 if the column is past the end). Reads use data kind 2 and writes use data kind 3.
- R6: Program-load (0x80) and erase-setup (0x60) requests are accepted and stored, producing no bus cycle and no done. The next confirm (0x10 or 0xD0) sends the stored command, the stored addresses and any write data, followed by the confirm byte as a second command.
- R7: A large page 0x00 read adds the second command 0x30, and a random data out (0x05) adds 0xE0. For reads, the second command comes before the data. For a program, the confirm byte comes after the data.
- R8: `ctl_word` layout: bit 31 = 1 (start); bits 30:27 = {1, address cycles - 1} when there are address cycles, else 0; bit 26 = read phase; bit 25 = write phase; bit 19 = chip select; bits 7:0 = the operation sent first. All other bits are 0.
- R9: After the last bus cycle, the block waits for `flash_rdy`. `done` pulses for exactly one cycle, in the cycle after the first wait cycle in which `flash_rdy` is high, and `timed_out` is 0.
- R10: If `flash_rdy` stays low for `tmo_limit` wait cycles (a limit of 0 counts as 1), `done` pulses with `timed_out` = 1. Ready seen in the same wait cycle as expiry counts as success.
- R11: `req_ready` is low while bus cycles or the wait are in progress. While a setup is stored, it is high only for a confirm byte.
- R12: After reset, `req_ready` = 1, `bus_valid` = 0, `done` = 0 and `ctl_word` = 0. Bus kind codes: 0 = command, 1 = address, 2 = data read, 3 = data write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request can be taken this cycle |
| req_cmd | input | 8 | Operation byte |
| req_col_en | input | 1 | Column field is present |
| req_col | input | 16 | Column |
| req_page_en | input | 1 | Page field is present |
| req_page | input | 24 | Page (row) address |
| req_cs | input | 1 | Chip-select level |
| tmo_limit | input | TMO_W | Ready wait limit in cycles |
| flash_rdy | input | 1 | Flash ready line |
| bus_valid | output | 1 | A bus cycle is presented |
| bus_kind | output | 2 | 0 cmd, 1 addr, 2 data read, 3 data write |
| bus_byte | output | 8 | Command or address byte (0 in data cycles) |
| ctl_word | output | 32 | Control word of the last launch |
| done | output | 1 | One-cycle completion pulse |
| timed_out | output | 1 | Completion was a timeout (valid with done) |

## Verification
The two functions that can meet in the same cycle are the ready detector and the timeout expiry. Both evaluate the last permitted wait cycle. The bench lets `flash_rdy` stay low and raises it exactly in the wait cycle where the count reaches `tmo_limit`. It then expects a done with `timed_out` low, after the same number of wait cycles as the pure timeout case. A separate run leaves ready low to confirm that the expiry alone sets the flag.

// File: rtl/nseq_pkg.sv
package nseq_pkg;

  localparam int COL_W = 16;
  localparam int ROW_W = 24;
  localparam int ABYTES = 5;

  localparam logic [7:0] OP_READ0     = 8'h00;
  localparam logic [7:0] OP_READ1     = 8'h01;
  localparam logic [7:0] OP_RNDOUT    = 8'h05;
  localparam logic [7:0] OP_PROG      = 8'h10;
  localparam logic [7:0] OP_READSTART = 8'h30;
  localparam logic [7:0] OP_SPARE     = 8'h50;
  localparam logic [7:0] OP_ERASE1    = 8'h60;
  localparam logic [7:0] OP_STATUS    = 8'h70;
  localparam logic [7:0] OP_SEQIN     = 8'h80;
  localparam logic [7:0] OP_READID    = 8'h90;
  localparam logic [7:0] OP_ERASE2    = 8'hD0;
  localparam logic [7:0] OP_RNDSTART  = 8'hE0;

  localparam logic [1:0] BK_CMD  = 2'd0;
  localparam logic [1:0] BK_ADDR = 2'd1;
  localparam logic [1:0] BK_DRD  = 2'd2;
  localparam logic [1:0] BK_DWR  = 2'd3;

  typedef struct packed {
    logic [7:0]          op1;
    logic                has_op2;
    logic [7:0]          op2;
    logic [2:0]          naddr;
    logic [8*ABYTES-1:0] abytes;
    logic                rd;
    logic                wr;
    logic [15:0]         dlen;
    logic [31:0]         ctl;
  } plan_t;

  // address cycle count from which fields are present
  function automatic logic [2:0] addr_cycles(input logic col_en, input logic page_en,
                                             input logic long_row);
    logic [2:0] n;
    n = col_en ? 3'd2 : 3'd0;
    if (page_en) n = n + 3'd2 + {2'b00, long_row};
    return n;
  endfunction

  // bytes from the start column to the end of page plus spare
  function automatic logic [15:0] span_len(input logic [15:0] total, input logic [15:0] col);
    return (col >= total) ? 16'd0 : total - col;
  endfunction

  function automatic logic [31:0] pack_ctl(input logic [7:0] op, input logic [2:0] naddr,
                                           input logic rd, input logic wr, input logic cs);
    logic [3:0] fld;
    fld = (naddr == 3'd0) ? 4'd0 : {1'b1, naddr - 3'd1};
    return {1'b1, fld, rd, wr, 5'd0, cs, 11'd0, op};
  endfunction

endpackage

// File: rtl/nseq_decode.sv
module nseq_decode
  import nseq_pkg::*;
#(
  parameter int PAGE_BYTES  = 2048,
  parameter int SPARE_BYTES = 64,
  parameter int LONG_ROW    = 1
) (
  input  logic [7:0]       cmd,
  input  logic             col_en,
  input  logic [COL_W-1:0] col,
  input  logic             page_en,
  input  logic [ROW_W-1:0] page,
  input  logic             cs,
  output plan_t            plan,
  output logic             is_setup,
  output logic             is_confirm
);
  localparam logic [15:0] TOTAL  = 16'(PAGE_BYTES + SPARE_BYTES);
  localparam logic [15:0] PAGE16 = 16'(PAGE_BYTES);
  localparam bit          LARGE  = (PAGE_BYTES > 512);

  logic [7:0]       op;
  logic [15:0]      col_eff;
  logic [15:0]      a1;
  logic [ROW_W-1:0] a2;
  logic             short_rd;
  logic             long_rd;

  always_comb begin
    op      = cmd;
    col_eff = col_en ? col : 16'd0;
    if (LARGE && cmd == OP_SPARE) begin
      op      = OP_READ0;
      col_eff = col_eff + PAGE16;
    end
    short_rd = (op == OP_READID) || (op == OP_STATUS);
    long_rd  = (op == OP_READ0) || (op == OP_READ1) || (op == OP_SPARE) || (op == OP_RNDOUT);
    a1 = col_en ? col_eff : (page_en ? page[15:0] : 16'd0);
    a2 = col_en ? page : {16'd0, page[ROW_W-1:16]};

    plan         = '0;
    plan.op1     = op;
    plan.naddr   = short_rd ? 3'd1 : addr_cycles(col_en, page_en, 1'(LONG_ROW));
    plan.abytes  = {a2, a1};
    plan.rd      = short_rd || long_rd;
    plan.wr      = (op == OP_SEQIN);
    plan.dlen    = short_rd ? 16'd4 :
                   (long_rd || plan.wr) ? span_len(TOTAL, col_eff) : 16'd0;
    plan.has_op2 = (op == OP_RNDOUT) || (LARGE && op == OP_READ0);
    plan.op2     = (op == OP_RNDOUT) ? OP_RNDSTART : OP_READSTART;
    plan.ctl     = pack_ctl(op, plan.naddr, plan.rd, plan.wr, cs);
  end

  assign is_setup   = (cmd == OP_SEQIN) || (cmd == OP_ERASE1);
  assign is_confirm = (cmd == OP_PROG) || (cmd == OP_ERASE2);

endmodule

// File: rtl/nseq_wait_timer.sv
module nseq_wait_timer #(
  parameter int CNT_W = 20
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             active,
  input  logic             rdy,
  input  logic [CNT_W-1:0] limit,
  output logic             hit_ready,
  output logic             expire
);
  logic [CNT_W-1:0] cnt;
  logic [CNT_W:0]   cnt_next;

  assign cnt_next  = {1'b0, cnt} + 1'b1;
  assign hit_ready = active && rdy;
  assign expire    = active && !rdy && (cnt_next >= {1'b0, limit});

  always_ff @(posedge clk) begin
    if (!rst_n)                     cnt <= '0;
    else if (!active)               cnt <= '0;
    else if (!hit_ready && !expire) cnt <= cnt + 1'b1;
  end

endmodule

// File: rtl/nseq_cycle_gen.sv
module nseq_cycle_gen
  import nseq_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        launch,
  input  plan_t       launch_plan,
  input  logic        finish,
  output logic        idle,
  output logic        in_wait,
  output logic        bus_valid,
  output logic [1:0]  bus_kind,
  output logic [7:0]  bus_byte,
  output logic [31:0] ctl_word
);
  typedef enum logic [2:0] {
    PH_IDLE, PH_CMD1, PH_ADDR, PH_OP2A, PH_DATA, PH_OP2B, PH_WAIT
  } phase_e;

  phase_e      ph, ph_nx;
  phase_e      after_cmd1, after_addr, after_op2a, after_data;
  plan_t       pl;
  logic [15:0] idx, idx_nx;

  // successor of each phase, skipping the ones the plan leaves out
  always_comb begin
    after_data = (pl.has_op2 && !pl.rd) ? PH_OP2B : PH_WAIT;
    after_op2a = (pl.dlen != 16'd0) ? PH_DATA : after_data;
    after_addr = (pl.has_op2 && pl.rd) ? PH_OP2A : after_op2a;
    after_cmd1 = (pl.naddr != 3'd0) ? PH_ADDR : after_addr;
  end

  always_comb begin
    ph_nx  = ph;
    idx_nx = idx;
    unique case (ph)
      PH_IDLE: if (launch) begin ph_nx = PH_CMD1; idx_nx = 16'd0; end
      PH_CMD1: ph_nx = after_cmd1;
      PH_ADDR:
        if (idx == 16'(pl.naddr) - 16'd1) begin ph_nx = after_addr; idx_nx = 16'd0; end
        else idx_nx = idx + 16'd1;
      PH_OP2A: ph_nx = after_op2a;
      PH_DATA:
        if (idx == pl.dlen - 16'd1) begin ph_nx = after_data; idx_nx = 16'd0; end
        else idx_nx = idx + 16'd1;
      PH_OP2B: ph_nx = PH_WAIT;
      PH_WAIT: if (finish) ph_nx = PH_IDLE;
      default: ph_nx = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ph  <= PH_IDLE;
      idx <= 16'd0;
      pl  <= '0;
    end else begin
      ph  <= ph_nx;
      idx <= idx_nx;
      if (ph == PH_IDLE && launch) pl <= launch_plan;
    end
  end

  assign idle     = (ph == PH_IDLE);
  assign in_wait  = (ph == PH_WAIT);
  assign ctl_word = pl.ctl;

  always_comb begin
    bus_valid = 1'b1;
    bus_kind  = BK_CMD;
    bus_byte  = 8'h00;
    unique case (ph)
      PH_CMD1: bus_byte = pl.op1;
      PH_ADDR: begin
        bus_kind = BK_ADDR;
        bus_byte = pl.abytes[{idx[2:0], 3'b000} +: 8];
      end
      PH_OP2A, PH_OP2B: bus_byte = pl.op2;
      PH_DATA: bus_kind = pl.wr ? BK_DWR : BK_DRD;
      default: bus_valid = 1'b0;
    endcase
  end

endmodule

// File: rtl/nand_cmd_seq.sv
module nand_cmd_seq
  import nseq_pkg::*;
#(
  parameter int PAGE_BYTES  = 2048,
  parameter int SPARE_BYTES = 64,
  parameter int LONG_ROW    = 1,
  parameter int TMO_W       = 20
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic [7:0]       req_cmd,
  input  logic             req_col_en,
  input  logic [15:0]      req_col,
  input  logic             req_page_en,
  input  logic [23:0]      req_page,
  input  logic             req_cs,
  input  logic [TMO_W-1:0] tmo_limit,
  input  logic             flash_rdy,
  output logic             bus_valid,
  output logic [1:0]       bus_kind,
  output logic [7:0]       bus_byte,
  output logic [31:0]      ctl_word,
  output logic             done,
  output logic             timed_out
);
  plan_t dec_plan, held_plan, go_plan;
  logic  dec_setup, dec_confirm;
  logic  held_valid;
  logic  gen_idle, gen_wait;
  // named internal events, watched by the checker
  logic  ev_accept, ev_store, ev_launch, ev_rdy_hit, ev_expire;

  nseq_decode #(
    .PAGE_BYTES (PAGE_BYTES),
    .SPARE_BYTES(SPARE_BYTES),
    .LONG_ROW   (LONG_ROW)
  ) dec_i (
    .cmd       (req_cmd),
    .col_en    (req_col_en),
    .col       (req_col),
    .page_en   (req_page_en),
    .page      (req_page),
    .cs        (req_cs),
    .plan      (dec_plan),
    .is_setup  (dec_setup),
    .is_confirm(dec_confirm)
  );

  assign req_ready = gen_idle && (!held_valid || dec_confirm);
  assign ev_accept = req_valid && req_ready;
  assign ev_store  = ev_accept && dec_setup;
  assign ev_launch = ev_accept && !dec_setup;

  always_comb begin
    go_plan = dec_plan;
    if (held_valid && dec_confirm) begin
      go_plan         = held_plan;
      go_plan.has_op2 = 1'b1;
      go_plan.op2     = req_cmd;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      held_valid <= 1'b0;
      held_plan  <= '0;
    end else if (ev_store) begin
      held_valid <= 1'b1;
      held_plan  <= dec_plan;
    end else if (ev_launch) begin
      held_valid <= 1'b0;
    end
  end

  nseq_cycle_gen gen_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .launch     (ev_launch),
    .launch_plan(go_plan),
    .finish     (ev_rdy_hit || ev_expire),
    .idle       (gen_idle),
    .in_wait    (gen_wait),
    .bus_valid  (bus_valid),
    .bus_kind   (bus_kind),
    .bus_byte   (bus_byte),
    .ctl_word   (ctl_word)
  );

  nseq_wait_timer #(.CNT_W(TMO_W)) tmr_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .active   (gen_wait),
    .rdy      (flash_rdy),
    .limit    (tmo_limit),
    .hit_ready(ev_rdy_hit),
    .expire   (ev_expire)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      done      <= 1'b0;
      timed_out <= 1'b0;
    end else begin
      done      <= ev_rdy_hit || ev_expire;
      timed_out <= ev_expire;
    end
  end

endmodule

// File: rtl/nseq_checker.sv
module nseq_checker (
  input logic        clk,
  input logic        rst_n,
  input logic        req_valid,
  input logic        req_ready,
  input logic [7:0]  req_cmd,
  input logic        bus_valid,
  input logic [31:0] ctl_word,
  input logic        done,
  input logic        timed_out,
  input logic        held_valid,
  input logic        ev_store,
  input logic        ev_launch,
  input logic        ev_rdy_hit,
  input logic        ev_expire
);
  p_done_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  p_quiet_on_done_r9: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !bus_valid);

  p_ready_outcome_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ev_rdy_hit |=> (done && !timed_out));

  p_expire_outcome_r10: assert property (@(posedge clk) disable iff (!rst_n)
    ev_expire |=> (done && timed_out));

  p_flag_with_done_r10: assert property (@(posedge clk) disable iff (!rst_n)
    timed_out |-> done);

  p_no_take_busy_r11: assert property (@(posedge clk) disable iff (!rst_n)
    bus_valid |-> !req_ready);

  p_confirm_only_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (held_valid && req_valid && req_ready) |-> (req_cmd == 8'h10 || req_cmd == 8'hD0));

  p_setup_silent_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ev_store |=> (!bus_valid && held_valid));

  p_launch_start_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ev_launch |=> (bus_valid && ctl_word[31]));

endmodule

bind nand_cmd_seq nseq_checker chk_i (
  .clk       (clk),
  .rst_n     (rst_n),
  .req_valid (req_valid),
  .req_ready (req_ready),
  .req_cmd   (req_cmd),
  .bus_valid (bus_valid),
  .ctl_word  (ctl_word),
  .done      (done),
  .timed_out (timed_out),
  .held_valid(held_valid),
  .ev_store  (ev_store),
  .ev_launch (ev_launch),
  .ev_rdy_hit(ev_rdy_hit),
  .ev_expire (ev_expire)
);

// File: tb/nand_cmd_seq_tb_top.sv
`timescale 1ns/1ps
module nand_cmd_seq_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [7:0]  req_cmd = 8'h00;
  logic        req_col_en = 1'b0;
  logic [15:0] req_col = 16'h0;
  logic        req_page_en = 1'b0;
  logic [23:0] req_page = 24'h0;
  logic        req_cs = 1'b0;
  logic [19:0] tmo_limit = 20'd1000;
  logic        flash_rdy = 1'b1;
  logic        bus_valid;
  logic [1:0]  bus_kind;
  logic [7:0]  bus_byte;
  logic [31:0] ctl_word;
  logic        done;
  logic        timed_out;

  always #2 clk = ~clk;

  nand_cmd_seq dut_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_cmd(req_cmd), .req_col_en(req_col_en), .req_col(req_col),
    .req_page_en(req_page_en), .req_page(req_page), .req_cs(req_cs),
    .tmo_limit(tmo_limit), .flash_rdy(flash_rdy), .bus_valid(bus_valid),
    .bus_kind(bus_kind), .bus_byte(bus_byte), .ctl_word(ctl_word),
    .done(done), .timed_out(timed_out)
  );

  typedef struct packed {
    logic [7:0]  cmd;
    logic        col_en;
    logic [15:0] col;
    logic        page_en;
    logic [23:0] page;
    logic        cs;
    logic [7:0]  c1;
    logic [2:0]  naddr;
    logic [39:0] ab;
    logic [8:0]  c2;
    logic [15:0] dlen;
    logic        rd;
    logic [31:0] ctl;
  } vec_t;

  localparam vec_t VECS [8] = '{
    '{8'h00, 1'b1, 16'h0010, 1'b1, 24'h012345, 1'b0, 8'h00, 3'd5, 40'h0001234500_10 >> 0, 9'h030, 16'd2096, 1'b1, 32'hE4000000},
    '{8'h50, 1'b1, 16'h0000, 1'b1, 24'h000007, 1'b1, 8'h00, 3'd5, 40'h0000070800, 9'h030, 16'd64,   1'b1, 32'hE4080000},
    '{8'h90, 1'b1, 16'h0000, 1'b0, 24'h000000, 1'b0, 8'h90, 3'd1, 40'h0000000000, 9'h100, 16'd4,    1'b1, 32'hC4000090},
    '{8'h70, 1'b0, 16'h0000, 1'b0, 24'h000000, 1'b0, 8'h70, 3'd1, 40'h0000000000, 9'h100, 16'd4,    1'b1, 32'hC4000070},
    '{8'h05, 1'b1, 16'h0100, 1'b0, 24'h000000, 1'b1, 8'h05, 3'd2, 40'h0000000100, 9'h0E0, 16'd1856, 1'b1, 32'hCC080005},
    '{8'hFF, 1'b0, 16'h0000, 1'b0, 24'h000000, 1'b0, 8'hFF, 3'd0, 40'h0000000000, 9'h100, 16'd0,    1'b0, 32'h800000FF},
    '{8'h01, 1'b1, 16'h0020, 1'b1, 24'h000001, 1'b0, 8'h01, 3'd5, 40'h0000010020, 9'h100, 16'd2080, 1'b1, 32'hE4000001},
    '{8'h00, 1'b0, 16'h0000, 1'b1, 24'h03BEEF, 1'b0, 8'h00, 3'd3, 40'h000003BEEF, 9'h030, 16'd2112, 1'b1, 32'hD4000000}
  };

  int tests = 0;
  int fails = 0;

  // captured view of one operation
  logic [7:0]  r_c1;
  int          r_naddr;
  logic [39:0] r_ab;
  logic [8:0]  r_c2;
  bit          r_c2_late;
  int          r_drd, r_dwr, r_waits, r_busy_ready;
  bit          r_done, r_tmo;
  logic [31:0] r_ctl;

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic issue(input logic [7:0] c, input logic ce, input logic [15:0] col,
                       input logic pe, input logic [23:0] pg, input logic cs);
    @(negedge clk);
    req_cmd = c; req_col_en = ce; req_col = col; req_page_en = pe; req_page = pg; req_cs = cs;
    req_valid = 1'b1;
    #1;
    while (!req_ready) begin @(negedge clk); #1; end
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic capture(input int collide_at);
    bit seen1;
    seen1 = 0; r_c1 = 8'h0; r_naddr = 0; r_ab = '0; r_c2 = 9'h100; r_c2_late = 0;
    r_drd = 0; r_dwr = 0; r_waits = 0; r_busy_ready = 0; r_done = 0; r_tmo = 0; r_ctl = '0;
    for (int k = 0; k < 6000; k++) begin
      if (bus_valid) begin
        if (req_ready) r_busy_ready++;
        case (bus_kind)
          2'd0: if (!seen1) begin r_c1 = bus_byte; seen1 = 1; end
                else begin r_c2 = {1'b0, bus_byte}; r_c2_late = (r_drd + r_dwr) > 0; end
          2'd1: begin if (r_naddr < 5) r_ab[8*r_naddr +: 8] = bus_byte; r_naddr++; end
          2'd2: r_drd++;
          default: r_dwr++;
        endcase
      end else if (done) begin
        r_done = 1; r_tmo = timed_out; r_ctl = ctl_word;
        break;
      end else begin
        r_waits++;
        if (r_waits == collide_at) flash_rdy = 1'b1;
      end
      @(negedge clk);
    end
  endtask

  function automatic logic [39:0] amask(input int n);
    return (n == 0) ? 40'h0 : ~(40'hFF_FFFF_FFFF << (8 * n));
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    tests++; fails++;
    $display("FAIL R9 watchdog: actual hung expected done");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    #1;
    // R12 reset state
    chk(req_ready == 1'b1, "R12", "ready after reset", req_ready, 1);
    chk(bus_valid == 1'b0, "R12", "bus idle after reset", bus_valid, 0);
    chk(done == 1'b0, "R12", "done low after reset", done, 0);
    chk(ctl_word == 32'h0, "R12", "ctl after reset", ctl_word, 0);

    // table of vectors
    foreach (VECS[i]) begin
      flash_rdy = 1'b1; tmo_limit = 20'd1000;
      issue(VECS[i].cmd, VECS[i].col_en, VECS[i].col, VECS[i].page_en, VECS[i].page, VECS[i].cs);
      capture(0);
      chk(r_c1 == VECS[i].c1, "R4", "first command", r_c1, VECS[i].c1);
      chk(r_naddr == int'(VECS[i].naddr), (VECS[i].cmd[7] ? "R3" : "R1"), "address cycles", r_naddr, VECS[i].naddr);
      chk((r_ab & amask(VECS[i].naddr)) == (VECS[i].ab & amask(VECS[i].naddr)), "R2", "address bytes",
          r_ab & amask(VECS[i].naddr), VECS[i].ab & amask(VECS[i].naddr));
      chk(r_c2 == VECS[i].c2 && !r_c2_late, "R7", "second command before data", r_c2, VECS[i].c2);
      chk((VECS[i].rd ? r_drd : r_dwr) == int'(VECS[i].dlen) && (VECS[i].rd ? r_dwr : r_drd) == 0,
          "R5", "data length", r_drd + r_dwr, VECS[i].dlen);
      chk(r_ctl == VECS[i].ctl, "R8", "control word", r_ctl, VECS[i].ctl);
      chk(r_done && !r_tmo && r_waits == 1, "R9", "done after one wait cycle", r_waits, 1);
      chk(r_busy_ready == 0, "R11", "ready low while busy", r_busy_ready, 0);
      @(negedge clk);
      chk(done == 1'b0, "R9", "done is one cycle", done, 0);
    end

    // erase: setup stored, other requests blocked, confirm issues
    issue(8'h60, 1'b0, 16'h0, 1'b1, 24'h00ABCD, 1'b0);
    repeat (3) begin
      chk(bus_valid == 1'b0 && done == 1'b0, "R6", "setup emits nothing", bus_valid, 0);
      @(negedge clk);
    end
    req_cmd = 8'h00; req_col_en = 1'b1; req_page_en = 1'b1; req_valid = 1'b1;
    #1;
    chk(req_ready == 1'b0, "R11", "non-confirm blocked while setup held", req_ready, 0);
    @(negedge clk);
    chk(bus_valid == 1'b0, "R11", "blocked request emits nothing", bus_valid, 0);
    req_valid = 1'b0;
    issue(8'hD0, 1'b0, 16'h0, 1'b0, 24'h0, 1'b0);
    capture(0);
    chk(r_c1 == 8'h60 && r_c2 == 9'h0D0, "R6", "erase setup then confirm", {r_c1, r_c2}, {8'h60, 9'h0D0});
    chk(r_naddr == 3 && r_ab[23:0] == 24'h00ABCD, "R2", "page-only erase address", r_ab[23:0], 24'h00ABCD);
    chk(r_ctl == 32'hD0000060, "R8", "erase control word", r_ctl, 32'hD0000060);

    // program: data then confirm byte
    issue(8'h80, 1'b1, 16'h0000, 1'b1, 24'h000042, 1'b0);
    issue(8'h10, 1'b0, 16'h0, 1'b0, 24'h0, 1'b0);
    capture(0);
    chk(r_c1 == 8'h80 && r_naddr == 5, "R6", "program load re-sent", r_c1, 8'h80);
    chk(r_dwr == 2112 && r_drd == 0, "R5", "program write length", r_dwr, 2112);
    chk(r_c2 == 9'h010 && r_c2_late, "R7", "confirm after data", r_c2, 9'h010);
    chk(r_ctl == 32'hE2000080, "R8", "program control word", r_ctl, 32'hE2000080);

    // timeout with ready held low
    flash_rdy = 1'b0; tmo_limit = 20'd5;
    issue(8'hFF, 1'b0, 16'h0, 1'b0, 24'h0, 1'b0);
    capture(0);
    chk(r_done && r_tmo, "R10", "timeout flagged", r_tmo, 1);
    chk(r_waits == 5, "R10", "timeout wait cycles", r_waits, 5);

    // ready rises in the expiry cycle: success
    flash_rdy = 1'b0; tmo_limit = 20'd5;
    issue(8'hFF, 1'b0, 16'h0, 1'b0, 24'h0, 1'b0);
    capture(5);
    chk(r_done && !r_tmo, "R10", "ready wins at expiry", r_tmo, 0);
    chk(r_waits == 5, "R10", "collision wait cycles", r_waits, 5);

    // limit 0 behaves as 1
    flash_rdy = 1'b0; tmo_limit = 20'd0;
    issue(8'hFF, 1'b0, 16'h0, 1'b0, 24'h0, 1'b0);
    capture(0);
    chk(r_done && r_tmo && r_waits == 1, "R10", "zero limit", r_waits, 1);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule